// File: doc/BRIEF.md
# Serial Clock-Calendar Slave

This block is the device end of a three-wire serial clock-calendar link. A host toggles an enable line, a serial clock and a data line one bit at a time. While enable is high, each falling edge of the serial clock moves one bit. The first eight edges carry a command byte and the next eight carry a data byte. Depending on the command, the block either returns a byte on its data output during the second half of the frame, or stores the data byte when the frame completes.

Readable sources are a battery-backed byte store kept inside the block, a status byte, a fixed zero byte, and calendar fields. The calendar fields come from external binary counters, and the block converts them to packed BCD on the fly. One write command clears a power-fail flag in the status byte and sends a one-cycle request to clear the matching interrupt status bit elsewhere in the system.

All inputs are sampled on the system clock `clk`. The serial clock is edge-detected against its value one system clock earlier. The output bit is registered and changes in the system clock cycle after the falling edge that produced it.

Top module: `rtc_serial_slave`

## Requirements
- R1: A frame bit is taken only on a falling edge of `ser_clk`, that is, when `ser_clk` was 1 in the previous `clk` cycle and is 0 now, and only while `ser_en` is 1. Edges seen while `ser_en` is 0 move nothing.
- R2: While `ser_en` is 0, the frame aborts. The bit count, the command and the data byte return to zero. `ser_dout` reads 0 one cycle later, and a partial write frame stores nothing.
- R3: Edges 0 to 7 shift the command in, most significant bit first. Edges 8 to 15 shift the data byte in, also most significant bit first. On data edge 8+j, `ser_dout` takes bit 7-j of the return byte, one `clk` cycle after the edge.
- R4: Commands 0x00 to 0x1F return the byte-store entry at that index. After reset, entry i holds (37*i+5) mod 256 when the default image is used.
- R5: At the 16th edge, commands 0x80 to 0x9F write the data byte into the entry at index command-0x80.
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day of month, month and two-digit year. Each is sent as packed BCD: tens in bits 7:4 and units in bits 3:0.
- R7: Commands 0x23 and 0x27 to 0x2F return 0x00. So do command 0x31, the write commands, and every other command not listed in R4, R6 or R8.
- R8: The status byte resets to 0x90, and command 0x30 returns it.
- R9: At the 16th edge, command 0xB1 with data bit 2 set clears status bits 3 and 4. In the following cycle it also raises `irq_clr_o` for exactly one `clk` cycle. With data bit 2 clear, command 0xB1 changes nothing and raises no pulse.
- R10: Once 16 edges have been taken, further edges in the same enable period are ignored. `ser_dout` holds its value and no further store takes place, until `ser_en` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Frame enable from the host |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial return bit |
| tm_sec | input | 6 | Seconds, binary 0-59 |
| tm_min | input | 6 | Minutes, binary 0-59 |
| tm_hour | input | 5 | Hours, binary 0-23 |
| tm_mday | input | 5 | Day of month, binary 1-31 |
| tm_mon | input | 4 | Month, binary 1-12 |
| tm_year | input | 7 | Two-digit year, binary 0-99 |
| irq_clr_o | output | 1 | One-cycle request to clear the power-fail interrupt bit |

## Verification
The bench sweeps every calendar field over its full range. A faulty binary-to-BCD split would show up on values such as 9, 10, 59 or 99, and a swapped field select would return the wrong field. It writes and reads back every byte-store entry, including index 0x1F next to the calendar range. An off-by-one decode would corrupt a neighbouring entry or answer for the wrong command.

The bench also aborts a write frame after twelve edges. A design that fails to clear its count on abort would misalign the next frame or store the partial byte. It then sends extra edges after the 16th. A counter that wraps instead of saturating would either rewrite the store or change the output bit.

The status-clear command is tried with and without data bit 2. A design that ignored that bit, or stretched the clear request over more than one cycle, would produce a wrong pulse.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

    localparam int unsigned FRAME_EDGES = 16;
    localparam int unsigned CNT_W       = $clog2(FRAME_EDGES + 1);

    localparam logic [7:0] STAT_RESET = 8'h90;
    localparam logic [7:0] STAT_CLRM  = 8'h18;
    localparam logic [7:0] CMD_STAT   = 8'h30;
    localparam logic [7:0] CMD_ZERO   = 8'h31;
    localparam logic [7:0] CMD_SCLR   = 8'hB1;
    localparam logic [7:0] WR_BASE    = 8'h80;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       cmd;
        logic [7:0]       dat;
        logic [7:0]       stat;
        logic             dout;
        logic             sclk_prev;
        logic             irq_clr;
    } frame_t;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [255:0] default_image();
        logic [255:0] img;
        for (int i = 0; i < 32; i++) begin
            img[8*i +: 8] = 8'((i * 37 + 5) % 256);
        end
        return img;
    endfunction

endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int unsigned        BYTES = 32,
    parameter logic [8*BYTES-1:0] IMAGE = '0,
    localparam int unsigned       AW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [BYTES];
    logic [7:0] mem_d [BYTES];

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= IMAGE[8*i +: 8];
            end
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/rtc_ret_mux.sv
module rtc_ret_mux
    import rtc_ser_pkg::*;
#(
    parameter int unsigned BYTES = 32
) (
    input  logic [7:0] cmd,
    input  logic [7:0] store_byte,
    input  logic [7:0] stat,
    input  logic [5:0] tm_sec,
    input  logic [5:0] tm_min,
    input  logic [4:0] tm_hour,
    input  logic [4:0] tm_mday,
    input  logic [3:0] tm_mon,
    input  logic [6:0] tm_year,
    output logic [7:0] ret
);

    always_comb begin
        ret = 8'h00;
        if (32'(cmd) < BYTES) begin
            ret = store_byte;
        end else begin
            case (cmd)
                8'h20:    ret = to_bcd({1'b0, tm_sec});
                8'h21:    ret = to_bcd({1'b0, tm_min});
                8'h22:    ret = to_bcd({2'b0, tm_hour});
                8'h24:    ret = to_bcd({2'b0, tm_mday});
                8'h25:    ret = to_bcd({3'b0, tm_mon});
                8'h26:    ret = to_bcd(tm_year);
                CMD_STAT: ret = stat;
                CMD_ZERO: ret = 8'h00;
                default:  ret = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_ser_pkg::*;
#(
    parameter int unsigned        RAM_BYTES  = 32,
    parameter logic [8*RAM_BYTES-1:0] INIT_IMAGE = default_image(),
    localparam int unsigned       AW         = $clog2(RAM_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_en,
    input  logic       ser_clk,
    input  logic       ser_din,
    output logic       ser_dout,
    input  logic [5:0] tm_sec,
    input  logic [5:0] tm_min,
    input  logic [4:0] tm_hour,
    input  logic [4:0] tm_mday,
    input  logic [3:0] tm_mon,
    input  logic [6:0] tm_year,
    output logic       irq_clr_o
);

    frame_t     q, d;
    logic       fall;
    logic       store_we;
    logic       is_wr;
    logic [7:0] store_byte;
    logic [7:0] ret_byte;

    rtc_byte_store #(.BYTES(RAM_BYTES), .IMAGE(INIT_IMAGE)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .addr  (q.cmd[AW-1:0]),
        .wdata (d.dat),
        .rdata (store_byte)
    );

    rtc_ret_mux #(.BYTES(RAM_BYTES)) u_mux (
        .cmd        (q.cmd),
        .store_byte (store_byte),
        .stat       (q.stat),
        .tm_sec     (tm_sec),
        .tm_min     (tm_min),
        .tm_hour    (tm_hour),
        .tm_mday    (tm_mday),
        .tm_mon     (tm_mon),
        .tm_year    (tm_year),
        .ret        (ret_byte)
    );

    assign fall  = q.sclk_prev & ~ser_clk;
    assign is_wr = (q.cmd >= WR_BASE) && (32'(q.cmd) < 32'(WR_BASE) + RAM_BYTES);

    always_comb begin
        d           = q;
        d.sclk_prev = ser_clk;
        d.irq_clr   = 1'b0;
        store_we    = 1'b0;
        if (!ser_en) begin
            d.cnt  = '0;
            d.cmd  = 8'h00;
            d.dat  = 8'h00;
            d.dout = 1'b0;
        end else if (fall && (q.cnt < CNT_W'(FRAME_EDGES))) begin
            if (q.cnt < CNT_W'(8)) begin
                d.cmd = {q.cmd[6:0], ser_din};
            end else begin
                d.dat  = {q.dat[6:0], ser_din};
                d.dout = ret_byte[~q.cnt[2:0]];
                if (q.cnt == CNT_W'(FRAME_EDGES - 1)) begin
                    store_we = is_wr;
                    if ((q.cmd == CMD_SCLR) && d.dat[2]) begin
                        d.stat    = q.stat & ~STAT_CLRM;
                        d.irq_clr = 1'b1;
                    end
                end
            end
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt       <= '0;
            q.cmd       <= 8'h00;
            q.dat       <= 8'h00;
            q.stat      <= STAT_RESET;
            q.dout      <= 1'b0;
            q.sclk_prev <= 1'b0;
            q.irq_clr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ser_dout  = q.dout;
    assign irq_clr_o = q.irq_clr;

    a_r10_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_EDGES));

    a_r10_hold_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && q.cnt == CNT_W'(FRAME_EDGES)) |=> $stable(ser_dout));

    a_r2_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> (!ser_dout && q.cnt == '0));

    a_r1_no_edge_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && !fall) |=> $stable(q.cnt));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |=> !irq_clr_o);

    a_r9_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |-> (q.stat[4:3] == 2'b00));

endmodule

// File: tb/sim_rtc_serial_slave.sv
module sim_rtc_serial_slave;

    localparam int CLK_HALF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b1;
    logic       ser_din = 1'b0;
    logic [5:0] tm_sec = '0;
    logic [5:0] tm_min = '0;
    logic [4:0] tm_hour = '0;
    logic [4:0] tm_mday = 5'd1;
    logic [3:0] tm_mon = 4'd1;
    logic [6:0] tm_year = '0;
    logic       ser_dout;
    logic       irq_clr_o;

    int total = 0;
    int bad = 0;

    always #CLK_HALF clk = ~clk;

    rtc_serial_slave u0 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .tm_sec(tm_sec),
        .tm_min(tm_min), .tm_hour(tm_hour), .tm_mday(tm_mday),
        .tm_mon(tm_mon), .tm_year(tm_year), .irq_clr_o(irq_clr_o)
    );

    function automatic logic [7:0] img(input int i);
        return 8'((i * 37 + 5) % 256);
    endfunction

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bits(input logic [7:0] c, input logic [7:0] dv, input int n,
                        output logic [7:0] r, output logic p);
        r = 8'h00;
        p = 1'b0;
        ser_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (i < 8) ? c[7-i] : dv[15-i];
            ser_clk = 1'b1;
            @(negedge clk);
            ser_din = b;
            ser_clk = 1'b0;
            @(negedge clk);
            if (i >= 8) r = {r[6:0], ser_dout};
            if (i == 15) p = irq_clr_o;
        end
    endtask

    task automatic end_frame();
        ser_clk = 1'b1;
        @(negedge clk);
        ser_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] c, output logic [7:0] r);
        logic p;
        bits(c, 8'h00, 16, r, p);
        end_frame();
    endtask

    task automatic wr(input logic [7:0] c, input logic [7:0] dv, output logic p);
        logic [7:0] r;
        bits(c, dv, 16, r, p);
        end_frame();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset values and status read
        check("R8 reset dout", {7'b0, ser_dout}, 8'h00);
        check("R9 reset irq_clr", {7'b0, irq_clr_o}, 8'h00);
        rd(8'h30, r);
        check("R8 status after reset", r, 8'h90);

        // R4 R3: read the reset image
        for (int i = 0; i < 32; i++) begin
            rd(8'(i), r);
            check($sformatf("R4 image[%0d]", i), r, img(i));
        end

        // R1: edges with enable low are ignored, frame afterwards aligned
        for (int i = 0; i < 10; i++) begin
            ser_clk = 1'b1; ser_din = 1'b1; @(negedge clk);
            ser_clk = 1'b0; @(negedge clk);
        end
        check("R1 dout with enable low", {7'b0, ser_dout}, 8'h00);
        rd(8'h03, r);
        check("R1 aligned after idle edges", r, img(3));

        // R5: write every entry, read back
        for (int i = 0; i < 32; i++) begin
            wr(8'(8'h80 + i), 8'(i ^ 8'h5A), p);
        end
        for (int i = 0; i < 32; i++) begin
            rd(8'(i), r);
            check($sformatf("R5 store[%0d]", i), r, 8'(i ^ 8'h5A));
        end

        // R2: aborted write after 12 edges stores nothing
        bits(8'h85, 8'hC3, 12, r, p);
        ser_clk = 1'b1;
        @(negedge clk);
        ser_en = 1'b0;
        @(negedge clk);
        check("R2 dout after abort", {7'b0, ser_dout}, 8'h00);
        rd(8'h05, r);
        check("R2 partial write discarded", r, 8'(5 ^ 8'h5A));

        // R10: extra edges after a read hold dout
        wr(8'h82, 8'h4F, p);
        bits(8'h02, 8'h00, 16, r, p);
        check("R10 read before extra edges", r, 8'h4F);
        bits(8'h00, 8'h00, 16, r, p);
        check("R10 dout held after extra edges", {7'b0, ser_dout}, 8'h01);
        end_frame();
        // R10: extra edges after a write do not rewrite
        bits(8'h81, 8'h11, 16, r, p);
        bits(8'h81, 8'hEE, 16, r, p);
        end_frame();
        rd(8'h01, r);
        check("R10 no second write", r, 8'h11);

        // R6: calendar sweeps
        for (int v = 0; v < 60; v++) begin
            tm_sec = 6'(v); rd(8'h20, r);
            check($sformatf("R6 sec %0d", v), r, bcd(v));
            tm_min = 6'(v); rd(8'h21, r);
            check($sformatf("R6 min %0d", v), r, bcd(v));
        end
        for (int v = 0; v < 24; v++) begin
            tm_hour = 5'(v); rd(8'h22, r);
            check($sformatf("R6 hour %0d", v), r, bcd(v));
        end
        for (int v = 1; v < 32; v++) begin
            tm_mday = 5'(v); rd(8'h24, r);
            check($sformatf("R6 mday %0d", v), r, bcd(v));
        end
        for (int v = 1; v < 13; v++) begin
            tm_mon = 4'(v); rd(8'h25, r);
            check($sformatf("R6 mon %0d", v), r, bcd(v));
        end
        for (int v = 0; v < 100; v++) begin
            tm_year = 7'(v); rd(8'h26, r);
            check($sformatf("R6 year %0d", v), r, bcd(v));
        end

        // R7: zero-returning commands
        tm_sec = 6'd59; tm_min = 6'd59; tm_hour = 5'd23;
        rd(8'h23, r); check("R7 cmd 23", r, 8'h00);
        for (int c = 8'h27; c < 8'h30; c++) begin
            rd(8'(c), r);
            check($sformatf("R7 cmd %02h", c), r, 8'h00);
        end
        rd(8'h31, r); check("R7 cmd 31", r, 8'h00);
        rd(8'h40, r); check("R7 cmd 40", r, 8'h00);
        rd(8'h85, r); check("R7 write cmd returns zero", r, 8'h00);

        // R9: status clear without bit 2
        wr(8'hB1, 8'hFB, p);
        check("R9 no pulse without bit2", {7'b0, p}, 8'h00);
        rd(8'h30, r);
        check("R9 status kept without bit2", r, 8'h90);
        // R9: status clear with bit 2, one-cycle pulse
        bits(8'hB1, 8'h04, 16, r, p);
        check("R9 pulse after 16th edge", {7'b0, p}, 8'h01);
        @(negedge clk);
        check("R9 pulse one cycle", {7'b0, irq_clr_o}, 8'h00);
        end_frame();
        rd(8'h30, r);
        check("R9 status after clear", r, 8'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule